// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an accumulator-style processor core. Each operation takes the working register value as one operand. The other operand is either a file register value or an immediate literal. The block produces a result and the strobe that writes it back. It also keeps a five-flag status byte, and later operations can read that byte, for example to chain the carry across the bytes of a wide sum.

An operation is presented on the inputs with `op_valid` high and takes effect on the next rising clock edge. After that edge the result is held on `result` and the updated status byte is on `status`. For exactly one cycle, one of the two write strobes pulses; `dest_sel` picks which one. When no legal operation is presented, nothing is written and all held state stays the same.

Top module: `acc_alu`

## Requirements
- R1: Status byte layout: carry at bit 0, digit carry at bit 1, zero at bit 2, overflow at bit 3, negative at bit 4. Bits 7..5 always read 0. After reset, `status`, `result`, `wr_work` and `wr_file` are all 0.
- R2: Op code 0 (add) gives W + B. Carry is set on a carry out of bit 7. For example, 0xFF + 0x01 gives 0x00 with carry and zero set.
- R3: On add-type operations, digit carry is set on a carry from bit 3 into bit 4. On subtract-type operations, digit carry is set when the low nibble produces no borrow.
- R4: After every executed operation, zero is set exactly when the 8-bit result is 0x00, and negative equals bit 7 of the result.
- R5: Overflow is set when two operands of the same sign give a result of the opposite sign. For example, 0x70 + 0x20 gives 0x90 with overflow and negative set.
- R6: Op code 1 (add with carry) gives W + B + C, where C is the current carry flag. This lets multi-byte sums chain.
- R7: Op code 2 (subtract) gives W − B. Carry is set exactly when W ≥ B, meaning no borrow.
- R8: Op code 3 (subtract with borrow) gives W − B − (1 − C). Carry is set when that difference needs no borrow.
- R9: Op codes 4, 5 and 6 (AND, OR, XOR of W and B) update only zero and negative. Carry, digit carry and overflow keep their values.
- R10: Op code 7 gives B + 1 and op code 8 gives B − 1. Both update all five flags with add and subtract meaning respectively.
- R11: An executed operation with `dest_sel` = 0 pulses `wr_work`, and with `dest_sel` = 1 pulses `wr_file`. The strobe is high for exactly the one cycle after the operation's edge. The two strobes are never high together.
- R12: Operand B is `lit_in` when `use_lit` = 1 and `file_in` otherwise.
- R13: A cycle with `op_valid` low, or with an op code from 9 to 15, writes nothing and leaves `result` and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute the presented operation at the next edge |
| op_code | input | 4 | Operation select (0..8 legal) |
| work_in | input | 8 | Working register value (operand W) |
| file_in | input | 8 | File register value |
| lit_in | input | 8 | Immediate literal |
| use_lit | input | 1 | 1 selects the literal as operand B |
| dest_sel | input | 1 | 0 writes back to working register, 1 to file register |
| result | output | 8 | Result of the last executed operation |
| wr_work | output | 1 | One-cycle write strobe for the working register |
| wr_file | output | 1 | One-cycle write strobe for the file register |
| status | output | 8 | Status byte (flags in bits 4..0) |

## Verification
The bench targets the flag boundaries that a faulty design would get wrong:
- Subtracting equal operands, and 0x00 − 0x01, separate "carry means no borrow" from "carry means borrow". A design that inverted the subtract carry would report the wrong value in both cases.
- The 0x0F + 0x01 and 0x10 − 0x01 cases expose a digit carry taken from the wrong bit, or one not inverted for subtraction.
- The signed boundaries 0x7F + 1 and 0x80 − 1 check overflow.
- A two-byte chained sum and a borrow-chained difference would come out wrong if the stored carry were ignored or used with the wrong polarity.
- Logic operations run after a carry-setting add. A design that cleared carry, digit carry or overflow on logic operations would fail there.
- Idle and undefined op codes are checked for stray write strobes and for changes to the held result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int STAT_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_N  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBB = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_mode_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_cout,
    output logic         ovf
);
    localparam int H  = W / 2;
    localparam int HU = W - H;

    logic [W-1:0] b_eff;
    logic [H:0]   lo_sum;
    logic [HU:0]  hi_sum;

    // Subtraction is a + ~b + cin, so carry outputs mean "no borrow".
    always_comb begin
        b_eff     = sub ? ~b : b;
        lo_sum    = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        half_cout = lo_sum[H];
        hi_sum    = {1'b0, a[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{HU{1'b0}}, half_cout};
        cout      = hi_sum[HU];
        sum       = {hi_sum[HU-1:0], lo_sum[H-1:0]};
        ovf       = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   mode,
    output logic [W-1:0] y
);
    import acc_alu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = (mode == LG_AND) ? (a[i] & b[i]) :
                      (mode == LG_OR)  ? (a[i] | b[i]) :
                                         (a[i] ^ b[i]);
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0]                  res,
    input  logic                          cout,
    input  logic                          half_cout,
    input  logic                          ovf,
    input  logic                          arith,
    input  logic [acc_alu_pkg::STAT_W-1:0] st_in,
    output logic [acc_alu_pkg::STAT_W-1:0] st_out
);
    import acc_alu_pkg::*;

    always_comb begin
        st_out         = '0;
        st_out[FLG_Z]  = (res == '0);
        st_out[FLG_N]  = res[W-1];
        if (arith) begin
            st_out[FLG_C]  = cout;
            st_out[FLG_DC] = half_cout;
            st_out[FLG_OV] = ovf;
        end else begin
            st_out[FLG_C]  = st_in[FLG_C];
            st_out[FLG_DC] = st_in[FLG_DC];
            st_out[FLG_OV] = st_in[FLG_OV];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           op_valid,
    input  logic [3:0]                     op_code,
    input  logic [W-1:0]                   work_in,
    input  logic [W-1:0]                   file_in,
    input  logic [W-1:0]                   lit_in,
    input  logic                           use_lit,
    input  logic                           dest_sel,
    output logic [W-1:0]                   result,
    output logic                           wr_work,
    output logic                           wr_file,
    output logic [acc_alu_pkg::STAT_W-1:0] status
);
    import acc_alu_pkg::*;

    typedef struct packed {
        logic [W-1:0]      res;
        logic              wr_w;
        logic              wr_f;
        logic [STAT_W-1:0] st;
    } alu_state_t;

    alu_state_t cur_q, nxt_d;

    alu_op_e      op;
    logic [W-1:0] opb;
    logic [W-1:0] add_a, add_b, add_sum, lg_y, res_sel;
    logic         add_sub, add_cin, add_co, add_hco, add_ov;
    logic         arith, legal;
    logic [1:0]   lg_mode;
    logic [STAT_W-1:0] st_new;

    assign op  = alu_op_e'(op_code);
    assign opb = use_lit ? lit_in : file_in;

    // Operation decode: steer the shared adder and pick the result source.
    always_comb begin
        add_a   = work_in;
        add_b   = opb;
        add_sub = 1'b0;
        add_cin = 1'b0;
        arith   = 1'b1;
        legal   = 1'b1;
        lg_mode = LG_AND;
        case (op)
            OP_ADD:  ;
            OP_ADDC: add_cin = cur_q.st[FLG_C];
            OP_SUB: begin
                add_sub = 1'b1;
                add_cin = 1'b1;
            end
            OP_SUBB: begin
                add_sub = 1'b1;
                add_cin = cur_q.st[FLG_C];
            end
            OP_AND: begin
                arith   = 1'b0;
                lg_mode = LG_AND;
            end
            OP_OR: begin
                arith   = 1'b0;
                lg_mode = LG_OR;
            end
            OP_XOR: begin
                arith   = 1'b0;
                lg_mode = LG_XOR;
            end
            OP_INC: begin
                add_a   = opb;
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_a   = opb;
                add_b   = '0;
                add_sub = 1'b1;
            end
            default: begin
                legal = 1'b0;
                arith = 1'b0;
            end
        endcase
    end

    acc_alu_addsub #(.W(W)) u_addsub (
        .a         (add_a),
        .b         (add_b),
        .sub       (add_sub),
        .cin       (add_cin),
        .sum       (add_sum),
        .cout      (add_co),
        .half_cout (add_hco),
        .ovf       (add_ov)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .a    (work_in),
        .b    (opb),
        .mode (lg_mode),
        .y    (lg_y)
    );

    assign res_sel = arith ? add_sum : lg_y;

    acc_alu_flags #(.W(W)) u_flags (
        .res       (res_sel),
        .cout      (add_co),
        .half_cout (add_hco),
        .ovf       (add_ov),
        .arith     (arith),
        .st_in     (cur_q.st),
        .st_out    (st_new)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.wr_w = 1'b0;
        nxt_d.wr_f = 1'b0;
        if (op_valid && legal) begin
            nxt_d.res  = res_sel;
            nxt_d.st   = st_new;
            nxt_d.wr_w = !dest_sel;
            nxt_d.wr_f = dest_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign result  = cur_q.res;
    assign wr_work = cur_q.wr_w;
    assign wr_file = cur_q.wr_f;
    assign status  = cur_q.st;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] work_in,
    input logic [W-1:0] file_in,
    input logic [W-1:0] lit_in,
    input logic         use_lit,
    input logic         dest_sel,
    input logic [W-1:0] result,
    input logic         wr_work,
    input logic         wr_file,
    input logic [7:0]   status
);
    logic [W-1:0] opb;
    logic         legal;
    logic         is_logic;

    assign opb      = use_lit ? lit_in : file_in;
    assign legal    = (op_code <= 4'd8);
    assign is_logic = (op_code == 4'd4) || (op_code == 4'd5) || (op_code == 4'd6);

    p_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:5] == 3'b000);

    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=>
        status[0] == (({1'b0, $past(work_in)} + {1'b0, $past(opb)}) > {1'b0, {W{1'b1}}}));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_work || wr_file) |-> (status[2] == (result == '0)));

    p_neg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_work || wr_file) |-> (status[4] == result[W-1]));

    p_sub_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=> status[0] == ($past(work_in) >= $past(opb)));

    p_logic_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic) |=> ($stable(status[1:0]) && $stable(status[3])));

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_work && wr_file));

    p_dest_work_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && legal && !dest_sel) |=> (wr_work && !wr_file));

    p_dest_file_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && legal && dest_sel) |=> (wr_file && !wr_work));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || !legal) |=>
        (!wr_work && !wr_file && $stable(status) && $stable(result)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .work_in  (work_in),
    .file_in  (file_in),
    .lit_in   (lit_in),
    .use_lit  (use_lit),
    .dest_sel (dest_sel),
    .result   (result),
    .wr_work  (wr_work),
    .wr_file  (wr_file),
    .status   (status)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] work_in = 8'd0, file_in = 8'd0, lit_in = 8'd0;
    logic       use_lit = 1'b0, dest_sel = 1'b0;
    logic [7:0] result;
    logic       wr_work, wr_file;
    logic [7:0] status;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] m_st  = 8'h00;
    logic [7:0] m_res = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .work_in(work_in), .file_in(file_in), .lit_in(lit_in),
        .use_lit(use_lit), .dest_sel(dest_sel), .result(result),
        .wr_work(wr_work), .wr_file(wr_file), .status(status)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Reference: returns {result, status} for one operation.
    function automatic logic [15:0] model(input int op, input int w, input int b, input logic [7:0] st);
        int r = 0, sv = 0, ci, bo;
        logic c, dc, z, n, ov;
        c  = st[0];
        dc = st[1];
        ov = st[3];
        ci = int'(st[0]);
        bo = 1 - ci;
        case (op)
            0: begin r = w + b; c = r > 255; dc = (w % 16 + b % 16) > 15; sv = sx(w) + sx(b); end
            1: begin r = w + b + ci; c = r > 255; dc = (w % 16 + b % 16 + ci) > 15; sv = sx(w) + sx(b) + ci; end
            2: begin r = w - b; c = w >= b; dc = (w % 16) >= (b % 16); sv = sx(w) - sx(b); end
            3: begin r = w - b - bo; c = w >= b + bo; dc = (w % 16) >= (b % 16 + bo); sv = sx(w) - sx(b) - bo; end
            4: r = w & b;
            5: r = w | b;
            6: r = w ^ b;
            7: begin r = b + 1; c = r > 255; dc = (b % 16 + 1) > 15; sv = sx(b) + 1; end
            8: begin r = b - 1; c = b >= 1; dc = (b % 16) >= 1; sv = sx(b) - 1; end
            default: r = 0;
        endcase
        r = r & 255;
        if (op <= 3 || op >= 7) ov = (sv > 127) || (sv < -128);
        z = (r == 0);
        n = (r >= 128);
        return {8'(r), 3'b000, n, ov, z, dc, c};
    endfunction

    task automatic run_op(input string tag, input int op, input logic [7:0] w, input logic [7:0] f,
                          input logic [7:0] lit, input logic ul, input logic dst);
        logic [15:0] e;
        logic        lg;
        logic [7:0]  b;
        lg = (op <= 8);
        b  = ul ? lit : f;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'(op); work_in = w; file_in = f;
        lit_in = lit; use_lit = ul; dest_sel = dst;
        @(posedge clk);
        @(negedge clk);
        if (lg) begin
            e = model(op, int'(w), int'(b), m_st);
            m_res = e[15:8];
            m_st  = e[7:0];
        end
        chk(tag, "result", int'(result), int'(m_res));
        chk(tag, "status", int'(status), int'(m_st));
        chk(tag, "wr_work", int'(wr_work), int'(lg && !dst));
        chk(tag, "wr_file", int'(wr_file), int'(lg && dst));
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "reset result", int'(result), 0);
        chk("R1", "reset status", int'(status), 0);
        chk("R1", "reset wr_work", int'(wr_work), 0);
        chk("R1", "reset wr_file", int'(wr_file), 0);
    endtask

    task automatic t_add;
        run_op("R2 ff+01", 0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0);
        chk("R2", "ff+01 status", int'(status), 8'h07);
        run_op("R2 plain", 0, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0);
        run_op("R3 nibble", 0, 8'h0F, 8'h01, 8'h00, 1'b0, 1'b0);
        chk("R3", "dc on 0f+01", int'(status[1]), 1);
    endtask

    task automatic t_overflow;
        run_op("R5 70+20", 0, 8'h70, 8'h20, 8'h00, 1'b0, 1'b0);
        chk("R5", "70+20 status", int'(status), 8'h18);
        run_op("R5 80+80", 0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0);
        run_op("R5 neg-pos", 0, 8'hF0, 8'h05, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_chain;
        run_op("R6 lo", 0, 8'hF0, 8'h20, 8'h00, 1'b0, 1'b0);
        run_op("R6 hi", 1, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0);
        chk("R6", "chained hi byte", int'(result), 8'h47);
        run_op("R6 no-cin", 1, 8'h12, 8'h34, 8'h00, 1'b0, 1'b0);
        chk("R6", "carry clear sum", int'(result), 8'h46);
    endtask

    task automatic t_sub;
        run_op("R7 equal", 2, 8'h42, 8'h42, 8'h00, 1'b0, 1'b0);
        chk("R7", "equal carry", int'(status[0]), 1);
        run_op("R7 borrow", 2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
        chk("R7", "borrow carry", int'(status[0]), 0);
        run_op("R3 sub nibble", 2, 8'h10, 8'h01, 8'h00, 1'b0, 1'b0);
        chk("R3", "dc borrow", int'(status[1]), 0);
        run_op("R5 sub ovf", 2, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_subb;
        // 0x0100 - 0x0001: low byte borrows, high byte consumes it.
        run_op("R8 lo", 2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
        run_op("R8 hi", 3, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
        chk("R8", "borrow chain hi", int'(result), 8'h00);
        run_op("R8 no-borrow", 3, 8'h50, 8'h20, 8'h00, 1'b0, 1'b0);
        chk("R8", "plain diff", int'(result), 8'h30);
    endtask

    task automatic t_logic;
        run_op("R9 setup", 0, 8'h7F, 8'h81, 8'h00, 1'b0, 1'b0);
        run_op("R9 and", 4, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b0);
        chk("R9", "and keeps carry", int'(status[0]), 1);
        run_op("R9 or", 5, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0);
        run_op("R9 xor", 6, 8'hA5, 8'hFF, 8'h00, 1'b0, 1'b0);
        run_op("R4 xor zero", 6, 8'h3C, 8'h3C, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_incdec;
        run_op("R10 inc 7f", 7, 8'h00, 8'h7F, 8'h00, 1'b0, 1'b1);
        run_op("R10 inc ff", 7, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1);
        run_op("R10 dec 00", 8, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
        run_op("R10 dec 80", 8, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1);
        run_op("R10 dec 01", 8, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_dest_and_sel;
        run_op("R11 to file", 0, 8'h01, 8'h02, 8'h00, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "strobe dropped wr_file", int'(wr_file), 0);
        chk("R11", "strobe dropped wr_work", int'(wr_work), 0);
        run_op("R12 literal", 0, 8'h10, 8'h99, 8'h05, 1'b1, 1'b0);
        chk("R12", "literal used", int'(result), 8'h15);
        run_op("R12 file", 0, 8'h10, 8'h99, 8'h05, 1'b0, 1'b0);
        chk("R12", "file used", int'(result), 8'hA9);
    endtask

    task automatic t_idle;
        logic [7:0] r0, s0;
        run_op("R13 prep", 2, 8'h05, 8'h09, 8'h00, 1'b0, 1'b0);
        r0 = result;
        s0 = status;
        @(negedge clk);
        op_code = 4'd0; work_in = 8'hFF; file_in = 8'hFF; op_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R13", "idle result", int'(result), int'(r0));
        chk("R13", "idle status", int'(status), int'(s0));
        chk("R13", "idle wr", int'(wr_work | wr_file), 0);
        for (int k = 9; k < 16; k++) begin
            run_op("R13 undefined", k, 8'hFF, 8'h01, 8'h00, 1'b0, k[0]);
        end
        chk("R13", "undef result", int'(result), int'(r0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_overflow();
        t_chain();
        t_sub();
        t_subb();
        t_logic();
        t_incdec();
        t_dest_and_sel();
        t_idle();
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule